// File: doc/BRIEF.md
# Filtered Dual Memory-Controller Event Counters

This block holds a small set of independent performance counters (two by default) beside the front end of a memory controller. Each counter has its own configuration word. The word holds a 4-bit event code, a master-ID filter enable, a region filter enable, and the master-ID and region values to match. Every clock cycle, each counter looks at the event strobes and status levels from the controller. It then decides whether its selected event happened and passes any filter that applies to that event.

Pulse-type events are accepted accesses, activate commands and priority elevations. Each pulse is one event, so a burst access adds exactly one. Level-type events count the cycles in which a level is high. These levels are four queue-full flags, a command-pending flag and a data-busy flag. A debug qualifier on a source keeps that source from being counted by the access-based and busy-cycle codes.

Software reaches the block through a simple register port. Writes take effect at the clock edge and reads are combinational. Writing a configuration word also clears the counter that belongs to it.

Top module: `memctl_evt_counters`

## Requirements
- R1: After reset, every configuration word and every counter reads as zero.
- R2: A write to configuration word i clears counter i at the same edge and leaves the other counter alone. Writes to counter addresses have no effect.
- R3: Code 0 adds one for each accepted access (`acc_vld`). Code 2 adds one per read access (`acc_wr`=0) and code 3 adds one per write access (`acc_wr`=1). One pulse adds exactly one, whatever the burst length behind it.
- R4: Code 1 adds one per activate pulse (`act_vld`). Code 8 adds one per priority-elevation pulse (`prio_vld`).
- R5: Codes 4, 5, 6 and 7 add one in each cycle in which `fifo_full` bit 0, 1, 2 or 3 is high (command, write-data, read-data and return-command queues, in that order). Code 9 adds one per cycle with `cmd_pend` high, and code 0xA adds one per cycle with `busy` high.
- R6: With the master filter enabled (config bit 5), codes 0, 1, 2, 3 and 8 count an event only when its master ID equals config bits [15:8].
- R7: With the region filter enabled (config bit 4), codes 2, 3 and 8 count an event only when its region equals config bits [17:16].
- R8: A filter enable set for a code that does not allow that filter is ignored, and the event is counted unfiltered.
- R9: An access with `acc_dbg` high is not counted by codes 0, 2 or 3. An activate with `act_dbg` high is not counted by code 1. A busy cycle with `busy_dbg` high is not counted by code 0xA.
- R10: Event codes 0xB to 0xF never increment their counter.
- R11: Each counter is CNT_W bits wide and wraps from all ones to zero.
- R12: The address is formed as {sel, idx}. With sel=0, index idx reads or writes configuration word idx, laid out as code [3:0], region enable [4], master enable [5], master match [15:8] and region match [17:16]; all other bits read as zero. With sel=1, index idx reads counter idx, zero-extended.
- R13: An event seen before edge k shows up on `reg_rdata` right after edge k. An event in the cycle of a configuration write to the same counter is lost to the clear. A new configuration applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register address {sel, idx} |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data |
| acc_vld | input | 1 | Access accepted pulse |
| acc_mid | input | MID_W (8) | Master ID of the access |
| acc_rgn | input | RGN_W (2) | Address region of the access |
| acc_wr | input | 1 | Access type: 1 write, 0 read |
| acc_dbg | input | 1 | Debug qualifier of the access |
| act_vld | input | 1 | Activate command pulse |
| act_mid | input | MID_W (8) | Master ID behind the activate |
| act_dbg | input | 1 | Debug qualifier of the activate |
| prio_vld | input | 1 | Priority elevation pulse |
| prio_mid | input | MID_W (8) | Master ID of the elevated request |
| prio_rgn | input | RGN_W (2) | Region of the elevated request |
| fifo_full | input | 4 | Queue-full levels: cmd, wdata, rdata, return cmd |
| cmd_pend | input | 1 | A command is pending |
| busy | input | 1 | Controller data path busy with reads or writes |
| busy_dbg | input | 1 | Debug qualifier of the current busy cycle |

## Verification
Every result is due one clock edge after its stimulus. Counters and configuration words are single registers, and the read path adds no delay. The bench drives inputs and the read address on the falling edge. Its reference model updates on the rising edge from those same inputs, and each falling edge compares `reg_rdata` with the model for the address driven one cycle before. As a result, a clear, an increment, a wrap or a lost same-cycle event is checked in exactly the cycle the design must show it.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

   // event selector codes
   localparam logic [3:0] EV_ACCESS   = 4'h0;
   localparam logic [3:0] EV_ACTIVATE = 4'h1;
   localparam logic [3:0] EV_READ     = 4'h2;
   localparam logic [3:0] EV_WRITE    = 4'h3;
   localparam logic [3:0] EV_CMDQ     = 4'h4;
   localparam logic [3:0] EV_WDQ      = 4'h5;
   localparam logic [3:0] EV_RDQ      = 4'h6;
   localparam logic [3:0] EV_RETQ     = 4'h7;
   localparam logic [3:0] EV_PRIO     = 4'h8;
   localparam logic [3:0] EV_PENDING  = 4'h9;
   localparam logic [3:0] EV_BUSY     = 4'hA;

   // configuration word layout
   localparam int CFG_CODE_LSB = 0;
   localparam int CFG_REN_BIT  = 4;
   localparam int CFG_MEN_BIT  = 5;
   localparam int CFG_MID_LSB  = 8;
   localparam int CFG_RGN_LSB  = 16;
   localparam int CFG_FIELD_W  = 8;

   function automatic logic region_allowed(input logic [3:0] code);
      return (code == EV_READ) || (code == EV_WRITE) || (code == EV_PRIO);
   endfunction

   function automatic logic master_allowed(input logic [3:0] code);
      return (code <= EV_WRITE) || (code == EV_PRIO);
   endfunction

endpackage

// File: rtl/evtcnt_cfg_reg.sv
module evtcnt_cfg_reg
   import evtcnt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MID_W  = 8,
   parameter int RGN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [3:0]        code,
   output logic              ren,
   output logic              men,
   output logic [MID_W-1:0]  mid_match,
   output logic [RGN_W-1:0]  rgn_match,
   output logic [DATA_W-1:0] cfg_word
);

   localparam logic [63:0] MASK64 = 64'h3F
                                  | (((64'h1 << MID_W) - 64'h1) << CFG_MID_LSB)
                                  | (((64'h1 << RGN_W) - 64'h1) << CFG_RGN_LSB);
   localparam logic [DATA_W-1:0] FIELD_MASK = MASK64[DATA_W-1:0];

   logic [DATA_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= wdata & FIELD_MASK;
      end
   end

   assign code      = cfg_q[CFG_CODE_LSB +: 4];
   assign ren       = cfg_q[CFG_REN_BIT];
   assign men       = cfg_q[CFG_MEN_BIT];
   assign mid_match = cfg_q[CFG_MID_LSB +: MID_W];
   assign rgn_match = cfg_q[CFG_RGN_LSB +: RGN_W];
   assign cfg_word  = cfg_q;

   // R12
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cfg_word == ($past(wdata) & FIELD_MASK));

endmodule

// File: rtl/evtcnt_select.sv
module evtcnt_select
   import evtcnt_pkg::*;
#(
   parameter int MID_W = 8,
   parameter int RGN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       code,
   input  logic             ren,
   input  logic             men,
   input  logic [MID_W-1:0] mid_match,
   input  logic [RGN_W-1:0] rgn_match,
   input  logic             acc_vld,
   input  logic [MID_W-1:0] acc_mid,
   input  logic [RGN_W-1:0] acc_rgn,
   input  logic             acc_wr,
   input  logic             acc_dbg,
   input  logic             act_vld,
   input  logic [MID_W-1:0] act_mid,
   input  logic             act_dbg,
   input  logic             prio_vld,
   input  logic [MID_W-1:0] prio_mid,
   input  logic [RGN_W-1:0] prio_rgn,
   input  logic [3:0]       fifo_full,
   input  logic             cmd_pend,
   input  logic             busy,
   input  logic             busy_dbg,
   output logic             hit
);

   logic mfilt, rfilt;
   logic acc_mid_ok, act_mid_ok, prio_mid_ok;
   logic acc_rgn_ok, prio_rgn_ok;
   logic acc_live;

   always_comb begin
      mfilt       = men && master_allowed(code);
      rfilt       = ren && region_allowed(code);
      acc_mid_ok  = !mfilt || (acc_mid == mid_match);
      act_mid_ok  = !mfilt || (act_mid == mid_match);
      prio_mid_ok = !mfilt || (prio_mid == mid_match);
      acc_rgn_ok  = !rfilt || (acc_rgn == rgn_match);
      prio_rgn_ok = !rfilt || (prio_rgn == rgn_match);
      acc_live    = acc_vld && !acc_dbg && acc_mid_ok;
   end

   always_comb begin
      case (code)
         EV_ACCESS:   hit = acc_live;
         EV_ACTIVATE: hit = act_vld && !act_dbg && act_mid_ok;
         EV_READ:     hit = acc_live && !acc_wr && acc_rgn_ok;
         EV_WRITE:    hit = acc_live && acc_wr && acc_rgn_ok;
         EV_CMDQ:     hit = fifo_full[0];
         EV_WDQ:      hit = fifo_full[1];
         EV_RDQ:      hit = fifo_full[2];
         EV_RETQ:     hit = fifo_full[3];
         EV_PRIO:     hit = prio_vld && prio_mid_ok && prio_rgn_ok;
         EV_PENDING:  hit = cmd_pend;
         EV_BUSY:     hit = busy && !busy_dbg;
         default:     hit = 1'b0;
      endcase
   end

   // R10
   reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code > EV_BUSY) |-> !hit);

   // R9
   dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_dbg && (code == EV_ACCESS || code == EV_READ || code == EV_WRITE)) |-> !hit);

   // R6
   mid_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (men && hit && (code == EV_ACCESS || code == EV_READ || code == EV_WRITE))
      |-> (acc_mid == mid_match));

   // R7
   rgn_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren && hit && code == EV_PRIO) |-> (prio_rgn == rgn_match));

endmodule

// File: rtl/evtcnt_accum.sv
module evtcnt_accum #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R11
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && (&cnt)) |=> (cnt == '0));

   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R13
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/memctl_evt_counters.sv
module memctl_evt_counters
   import evtcnt_pkg::*;
#(
   parameter  int NUM_CNT = 2,
   parameter  int CNT_W   = 32,
   parameter  int DATA_W  = 32,
   parameter  int MID_W   = 8,
   parameter  int RGN_W   = 2,
   localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
   localparam int ADDR_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              acc_vld,
   input  logic [MID_W-1:0]  acc_mid,
   input  logic [RGN_W-1:0]  acc_rgn,
   input  logic              acc_wr,
   input  logic              acc_dbg,
   input  logic              act_vld,
   input  logic [MID_W-1:0]  act_mid,
   input  logic              act_dbg,
   input  logic              prio_vld,
   input  logic [MID_W-1:0]  prio_mid,
   input  logic [RGN_W-1:0]  prio_rgn,
   input  logic [3:0]        fifo_full,
   input  logic              cmd_pend,
   input  logic              busy,
   input  logic              busy_dbg
);

   localparam int SLOTS = 1 << IDX_W;

   // elaboration-time parameter checks
   if (NUM_CNT < 1 || NUM_CNT > 16) begin : g_bad_num
      $error("NUM_CNT out of range");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (MID_W < 1 || MID_W > CFG_FIELD_W || RGN_W < 1 || RGN_W > CFG_FIELD_W) begin : g_bad_fld
      $error("filter field widths must lie in 1..8");
   end
   if (DATA_W < CFG_RGN_LSB + CFG_FIELD_W) begin : g_bad_data
      $error("DATA_W too narrow for the configuration layout");
   end

   logic [DATA_W-1:0] cfg_word [SLOTS];
   logic [DATA_W-1:0] cnt_ext  [SLOTS];
   logic [IDX_W-1:0]  idx;
   logic              sel_cnt;

   assign idx     = reg_addr[IDX_W-1:0];
   assign sel_cnt = reg_addr[IDX_W];

   for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
      if (gi < NUM_CNT) begin : g_live
         logic [3:0]       code;
         logic             ren, men, hit, cfg_we;
         logic [MID_W-1:0] mid_match;
         logic [RGN_W-1:0] rgn_match;
         logic [CNT_W-1:0] cnt_v;

         assign cfg_we = reg_we && !sel_cnt && (idx == IDX_W'(gi));

         evtcnt_cfg_reg #(.DATA_W(DATA_W), .MID_W(MID_W), .RGN_W(RGN_W)) u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we),
            .wdata     (reg_wdata),
            .code      (code),
            .ren       (ren),
            .men       (men),
            .mid_match (mid_match),
            .rgn_match (rgn_match),
            .cfg_word  (cfg_word[gi])
         );

         evtcnt_select #(.MID_W(MID_W), .RGN_W(RGN_W)) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .code      (code),
            .ren       (ren),
            .men       (men),
            .mid_match (mid_match),
            .rgn_match (rgn_match),
            .acc_vld   (acc_vld),
            .acc_mid   (acc_mid),
            .acc_rgn   (acc_rgn),
            .acc_wr    (acc_wr),
            .acc_dbg   (acc_dbg),
            .act_vld   (act_vld),
            .act_mid   (act_mid),
            .act_dbg   (act_dbg),
            .prio_vld  (prio_vld),
            .prio_mid  (prio_mid),
            .prio_rgn  (prio_rgn),
            .fifo_full (fifo_full),
            .cmd_pend  (cmd_pend),
            .busy      (busy),
            .busy_dbg  (busy_dbg),
            .hit       (hit)
         );

         evtcnt_accum #(.CNT_W(CNT_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_we),
            .inc   (hit),
            .cnt   (cnt_v)
         );

         if (CNT_W == DATA_W) begin : g_full
            assign cnt_ext[gi] = cnt_v;
         end else begin : g_pad
            assign cnt_ext[gi] = {{(DATA_W-CNT_W){1'b0}}, cnt_v};
         end
      end else begin : g_empty
         assign cfg_word[gi] = '0;
         assign cnt_ext[gi]  = '0;
      end
   end

   always_comb begin
      reg_rdata = sel_cnt ? cnt_ext[idx] : cfg_word[idx];
   end

   // R2
   cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel_cnt && idx == '0 && g_slot[0].g_live.hit == 1'b0
       && !(g_slot[0].g_live.cfg_we))
      |=> $stable(cnt_ext[0]));

endmodule

// File: tb/sim_memctl_evt_counters.sv
module sim_memctl_evt_counters;

   localparam int CW = 8;
   localparam logic [31:0] FMASK = 32'h0003_FF3F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_vld = 0, acc_wr = 0, acc_dbg = 0;
   logic [7:0]  acc_mid = '0, act_mid = '0, prio_mid = '0;
   logic [1:0]  acc_rgn = '0, prio_rgn = '0;
   logic        act_vld = 0, act_dbg = 0, prio_vld = 0;
   logic [3:0]  fifo_full = '0;
   logic        cmd_pend = 0, busy = 0, busy_dbg = 0;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   string       cur_req = "R1";

   logic [31:0] m_cfg [2];
   int unsigned m_cnt [2];

   always #5 clk = ~clk;

   memctl_evt_counters #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_vld(acc_vld), .acc_mid(acc_mid), .acc_rgn(acc_rgn), .acc_wr(acc_wr),
      .acc_dbg(acc_dbg), .act_vld(act_vld), .act_mid(act_mid), .act_dbg(act_dbg),
      .prio_vld(prio_vld), .prio_mid(prio_mid), .prio_rgn(prio_rgn),
      .fifo_full(fifo_full), .cmd_pend(cmd_pend), .busy(busy), .busy_dbg(busy_dbg)
   );

   // behavioural expectation of one counter's increment this cycle
   function automatic bit m_hit(input int i);
      logic [3:0] c;
      bit mf, rf, mok_a, mok_t, mok_p, rok_a, rok_p;
      c     = m_cfg[i][3:0];
      mf    = m_cfg[i][5] && (c <= 3 || c == 8);
      rf    = m_cfg[i][4] && (c == 2 || c == 3 || c == 8);
      mok_a = !mf || acc_mid == m_cfg[i][15:8];
      mok_t = !mf || act_mid == m_cfg[i][15:8];
      mok_p = !mf || prio_mid == m_cfg[i][15:8];
      rok_a = !rf || acc_rgn == m_cfg[i][17:16];
      rok_p = !rf || prio_rgn == m_cfg[i][17:16];
      if (c == 0) return acc_vld && !acc_dbg && mok_a;
      if (c == 1) return act_vld && !act_dbg && mok_t;
      if (c == 2) return acc_vld && !acc_dbg && !acc_wr && mok_a && rok_a;
      if (c == 3) return acc_vld && !acc_dbg && acc_wr && mok_a && rok_a;
      if (c >= 4 && c <= 7) return fifo_full[c-4];
      if (c == 8) return prio_vld && mok_p && rok_p;
      if (c == 9) return cmd_pend;
      if (c == 10) return busy && !busy_dbg;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_cfg[i] = '0;
            m_cnt[i] = 0;
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            bit h;
            h = m_hit(i);
            if (reg_we && reg_addr == 2'(i)) begin
               m_cfg[i] = reg_wdata & FMASK;
               m_cnt[i] = 0;
            end else if (h) begin
               m_cnt[i] = (m_cnt[i] + 1) % (1 << CW);
            end
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      if (a[1] == 1'b0) return m_cfg[a[0]];
      return 32'(m_cnt[a[0]]);
   endfunction

   function automatic logic [31:0] mk(input int code, input bit ren, input bit men,
                                      input int mid, input int rgn);
      return 32'(code & 15) | (32'(ren) << 4) | (32'(men) << 5)
             | (32'(mid & 255) << 8) | (32'(rgn & 3) << 16);
   endfunction

   task automatic cycle(input logic we, input logic [1:0] a, input logic [31:0] wd,
                        input bit ev);
      logic [31:0] e;
      @(negedge clk);
      e = exp_read(reg_addr);
      n_cmp++;
      if (reg_rdata !== e) begin
         n_bad++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, reg_addr,
                  reg_rdata, e);
      end
      reg_we    = we;
      reg_addr  = a;
      reg_wdata = wd;
      acc_vld   = ev && ($urandom % 2 == 0);
      acc_mid   = 8'($urandom % 4);
      acc_rgn   = 2'($urandom);
      acc_wr    = 1'($urandom);
      acc_dbg   = ev && ($urandom % 4 == 0);
      act_vld   = ev && ($urandom % 2 == 0);
      act_mid   = 8'($urandom % 4);
      act_dbg   = ev && ($urandom % 4 == 0);
      prio_vld  = ev && ($urandom % 2 == 0);
      prio_mid  = 8'($urandom % 4);
      prio_rgn  = 2'($urandom);
      fifo_full = ev ? 4'($urandom) : 4'h0;
      cmd_pend  = ev && ($urandom % 3 != 0);
      busy      = ev && ($urandom % 3 != 0);
      busy_dbg  = ev && ($urandom % 4 == 0);
   endtask

   task automatic run(input string req, input logic [31:0] c0, input logic [31:0] c1,
                      input int n, input bit poke);
      cur_req = req;
      cycle(1'b1, 2'd0, c0, 1);
      cycle(1'b1, 2'd1, c1, 1);
      for (int k = 0; k < n; k++) begin
         logic [1:0] a;
         a = 2'(k % 4);
         cycle(poke && a[1] && ($urandom % 3 == 0), a, $urandom, 1);
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of all four addresses
      for (int a = 0; a < 4; a++) cycle(1'b0, 2'(a), '0, 0);
      cycle(1'b0, 2'd0, '0, 0);
      // R12: layout and masking of configuration words
      run("R12", 32'hFFFF_FFFF, 32'h1234_5678, 24, 0);
      // R3: accesses, reads, writes
      run("R3", mk(0,0,0,0,0), mk(2,0,0,0,0), 200, 0);
      run("R3", mk(3,0,0,0,0), mk(0,0,0,0,0), 200, 0);
      // R4: activates and priority elevations
      run("R4", mk(1,0,0,0,0), mk(8,0,0,0,0), 200, 0);
      // R5: level events
      run("R5", mk(4,0,0,0,0), mk(5,0,0,0,0), 120, 0);
      run("R5", mk(6,0,0,0,0), mk(7,0,0,0,0), 120, 0);
      run("R5", mk(9,0,0,0,0), mk(10,0,0,0,0), 120, 0);
      // R6: master filter
      run("R6", mk(0,0,1,2,0), mk(1,0,1,1,0), 200, 0);
      run("R6", mk(2,0,1,3,0), mk(8,0,1,0,0), 200, 0);
      // R7: region filter
      run("R7", mk(2,1,0,0,1), mk(3,1,1,2,3), 200, 0);
      run("R7", mk(8,1,0,0,2), mk(8,1,1,1,0), 200, 0);
      // R8: enables on codes that do not permit them
      run("R8", mk(0,1,0,0,3), mk(4,1,1,3,1), 150, 0);
      run("R8", mk(9,1,1,2,2), mk(10,1,1,0,0), 150, 0);
      run("R8", mk(1,1,0,0,1), mk(7,0,1,1,0), 150, 0);
      // R9: debug qualifier on access and busy codes
      run("R9", mk(0,0,0,0,0), mk(10,0,0,0,0), 200, 0);
      run("R9", mk(1,0,0,0,0), mk(3,0,0,0,0), 200, 0);
      // R10: reserved codes
      run("R10", mk(11,0,0,0,0), mk(15,1,1,0,0), 100, 0);
      run("R10", mk(12,0,0,0,0), mk(13,0,0,0,0), 100, 0);
      // R11: wrap past 2**CW-1
      run("R11", mk(9,0,0,0,0), mk(10,0,0,0,0), 900, 0);
      // R2: writes to counter addresses ignored, independent clears
      run("R2", mk(0,0,0,0,0), mk(4,0,0,0,0), 300, 1);
      cur_req = "R2";
      for (int k = 0; k < 30; k++) begin
         cycle(1'b1, 2'd0, mk(9,0,0,0,0), 1);
         cycle(1'b0, 2'd3, '0, 1);
         cycle(1'b0, 2'd2, '0, 1);
         cycle(1'b0, 2'd3, '0, 1);
      end
      // R13: reconfiguration back to back with live events
      cur_req = "R13";
      for (int k = 0; k < 150; k++) begin
         cycle(1'b1, 2'($urandom % 2), mk($urandom % 11, 1'($urandom), 1'($urandom),
               $urandom % 4, $urandom % 4), 1);
         cycle(1'b0, 2'd2 + 2'($urandom % 2), '0, 1);
      end
      cycle(1'b0, 2'd2, '0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule